// File: doc/BRIEF.md
# Flash Chip-Select Window Decoder

This block sits in front of a serial flash controller and decides which of several flash chip selects owns a bus address in the controller's memory-mapped window. Each chip select has a segment register. The register holds a start field and an end field in coarse 8 MB units. Every valid address is compared against all segments, and the winning chip select is reported as a one-hot enable. The byte offset of the address inside that segment is reported with it. An address that falls in no segment raises an out-of-window flag.

The segment registers are written and read through a simple word-register port. The low boundary of the first segment and the high boundary of the last segment are fixed. The reset layout nests the second and third segments inside the first one. Overlaps are resolved by index: the higher chip select wins. The decode result is registered and appears one clock after the address is presented.

Top module: `flash_window_decoder`

## Requirements
- R1: After reset, the segment registers read 0x60400000 (chip select 0, covering 0x20000000 up to 0x2FFFFFFF), 0x54500000 (chip select 1, covering 0x28000000 up to 0x29FFFFFF) and 0x58540000 (chip select 2, covering 0x2A000000 up to 0x2BFFFFFF). The decode outputs are all zero.
- R2: Segment register i sits at register offset 0x30 + 4*i. The start field is bits [23:16] and the end field is bits [31:24], both counted in 8 MB units (address bit 23 upward). Bits [15:0] read as zero. A write to any other offset changes nothing, and any other offset reads as zero.
- R3: The start field of chip select 0 and the end field of the last chip select are read-only. Writes to those fields are ignored, while the other field of the same register is still updated.
- R4: An address matches a segment when start <= addr[31:23] < end. A segment whose end is less than or equal to its start never matches.
- R5: When several segments match, the highest-numbered chip select wins.
- R6: offset_o equals the bus address minus start*8 MB of the winning segment. On a miss, offset_o is zero.
- R7: Outputs are registered. dec_valid_o equals bus_valid_i from the previous cycle. When dec_valid_o is high, exactly one of miss_o or a nonzero cs_en_o is set. When dec_valid_o is low, both are zero.
- R8: cs_en_o never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| bus_valid_i | input | 1 | Bus address valid |
| bus_addr_i | input | 32 | Bus address |
| dec_valid_o | output | 1 | Decode result valid |
| cs_en_o | output | 3 | One-hot chip-select enable |
| offset_o | output | 32 | Offset inside the selected segment |
| miss_o | output | 1 | Address outside every segment |

## Verification
The segment fields decide the decode result. A corrupted start or end field therefore shows up in two ways: as a wrong readback on the register port, and one cycle after the next address near that boundary is presented, as a wrong chip-select enable or a spurious miss. A wrong start field also shifts offset_o for every hit in that segment. A broken priority shows only for addresses in overlapping regions, so the bench rebuilds overlapping layouts and probes them. The read-only fields are checked by reading them back after writes that try to change them.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_CS   = 3;
  localparam int ADDR_W   = 32;
  localparam int FIELD_W  = 8;
  localparam int UNIT_LSB = 23;
  localparam int REG_AW   = 8;
  localparam int REG_BASE = 'h30;
  localparam int LO_POS   = 16;
  localparam int HI_POS   = 24;

  typedef struct packed {
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;
  } seg_t;

  function automatic seg_t seg_default(input int idx);
    seg_t s;
    case (idx)
      0:       begin s.hi = 8'h60; s.lo = 8'h40; end
      1:       begin s.hi = 8'h54; s.lo = 8'h50; end
      2:       begin s.hi = 8'h58; s.lo = 8'h54; end
      default: begin s.hi = '0;    s.lo = '0;    end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fwd_seg_regs.sv
module fwd_seg_regs
  import fwd_pkg::*;
#(
  parameter int N_CS = NUM_CS,
  parameter int AW   = REG_AW,
  parameter int BASE = REG_BASE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output seg_t [N_CS-1:0]    segs_o
);
  seg_t [N_CS-1:0] seg_q;

  for (genvar i = 0; i < N_CS; i++) begin : g_slot
    localparam logic [AW-1:0] SLOT_OFF = AW'(BASE + 4 * i);
    logic hit_w;
    assign hit_w = we_i && (addr_i == SLOT_OFF);

    if (i == 0) begin : g_lo_ro
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) seg_q[i].lo <= seg_default(i).lo;
    end else begin : g_lo_rw
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    seg_q[i].lo <= seg_default(i).lo;
        else if (hit_w) seg_q[i].lo <= wdata_i[LO_POS +: FIELD_W];
    end

    if (i == N_CS - 1) begin : g_hi_ro
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) seg_q[i].hi <= seg_default(i).hi;
    end else begin : g_hi_rw
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    seg_q[i].hi <= seg_default(i).hi;
        else if (hit_w) seg_q[i].hi <= wdata_i[HI_POS +: FIELD_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CS; i++) begin
      if (addr_i == AW'(BASE + 4 * i)) begin
        rdata_o[LO_POS +: FIELD_W] = seg_q[i].lo;
        rdata_o[HI_POS +: FIELD_W] = seg_q[i].hi;
      end
    end
  end

  assign segs_o = seg_q;
endmodule

// File: rtl/fwd_seg_match.sv
module fwd_seg_match
  import fwd_pkg::*;
#(
  parameter int UNIT_W = ADDR_W - UNIT_LSB
) (
  input  logic [UNIT_W-1:0] unit_i,
  input  seg_t              seg_i,
  output logic              hit_o
);
  logic [UNIT_W-1:0] lo_ext, hi_ext;
  assign lo_ext = UNIT_W'(seg_i.lo);
  assign hi_ext = UNIT_W'(seg_i.hi);
  // end exclusive; hi <= lo gives an empty range
  assign hit_o = (unit_i >= lo_ext) && (unit_i < hi_ext);
endmodule

// File: rtl/fwd_arbiter.sv
module fwd_arbiter
  import fwd_pkg::*;
#(
  parameter int N_CS = NUM_CS,
  parameter int AW   = ADDR_W,
  localparam int SW  = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [N_CS-1:0]   hit_i,
  input  seg_t [N_CS-1:0]   segs_i,
  output logic              valid_o,
  output logic [N_CS-1:0]   cs_en_o,
  output logic [AW-1:0]     offset_o,
  output logic              miss_o
);
  logic [SW-1:0]  sel;
  logic           any;
  logic [AW-1:0]  base;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < N_CS; i++) begin
      if (hit_i[i]) begin
        sel = SW'(i);
        any = 1'b1;
      end
    end
    base = '0;
    base[UNIT_LSB +: FIELD_W] = segs_i[sel].lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      cs_en_o  <= '0;
      offset_o <= '0;
      miss_o   <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      cs_en_o  <= (valid_i && any) ? (N_CS'(1) << sel) : '0;
      offset_o <= (valid_i && any) ? (addr_i - base) : '0;
      miss_o   <= valid_i && !any;
    end
  end
endmodule

// File: rtl/flash_window_decoder.sv
module flash_window_decoder
  import fwd_pkg::*;
#(
  parameter int N_CS = NUM_CS,
  parameter int AW   = ADDR_W,
  parameter int RAW  = REG_AW,
  localparam int UNIT_W = AW - UNIT_LSB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic            bus_valid_i,
  input  logic [AW-1:0]   bus_addr_i,
  output logic            dec_valid_o,
  output logic [N_CS-1:0] cs_en_o,
  output logic [AW-1:0]   offset_o,
  output logic            miss_o
);
  seg_t [N_CS-1:0] segs;
  logic [N_CS-1:0] hits;

  fwd_seg_regs #(.N_CS(N_CS), .AW(RAW), .BASE(REG_BASE)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .segs_o  (segs)
  );

  for (genvar i = 0; i < N_CS; i++) begin : g_match
    fwd_seg_match #(.UNIT_W(UNIT_W)) u_match (
      .unit_i (bus_addr_i[AW-1:UNIT_LSB]),
      .seg_i  (segs[i]),
      .hit_o  (hits[i])
    );
  end

  fwd_arbiter #(.N_CS(N_CS), .AW(AW)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (bus_valid_i),
    .addr_i   (bus_addr_i),
    .hit_i    (hits),
    .segs_i   (segs),
    .valid_o  (dec_valid_o),
    .cs_en_o  (cs_en_o),
    .offset_o (offset_o),
    .miss_o   (miss_o)
  );
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker
  import fwd_pkg::*;
#(
  parameter int N_CS = NUM_CS,
  parameter int AW   = ADDR_W,
  parameter int RAW  = REG_AW
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [RAW-1:0]  reg_addr_i,
  input logic [31:0]     reg_rdata_o,
  input logic            bus_valid_i,
  input logic            dec_valid_o,
  input logic [N_CS-1:0] cs_en_o,
  input logic [AW-1:0]   offset_o,
  input logic            miss_o
);
  localparam logic [RAW-1:0] FIRST_OFF = RAW'(REG_BASE);
  localparam logic [RAW-1:0] LAST_OFF  = RAW'(REG_BASE + 4 * (N_CS - 1));
  localparam seg_t FIRST_DEF = seg_default(0);
  localparam seg_t LAST_DEF  = seg_default(N_CS - 1);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  assert_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_en_o));

  assert_hit_or_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (miss_o != (cs_en_o != '0)));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (cs_en_o == '0 && !miss_o));

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (dec_valid_o == $past(bus_valid_i)));

  assert_miss_offset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (offset_o == '0));

  assert_first_lo_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == FIRST_OFF) |-> (reg_rdata_o[LO_POS +: FIELD_W] == FIRST_DEF.lo));

  assert_last_hi_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == LAST_OFF) |-> (reg_rdata_o[HI_POS +: FIELD_W] == LAST_DEF.hi));

  assert_low_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[15:0] == 16'h0);
endmodule

bind flash_window_decoder fwd_checker #(.N_CS(N_CS), .AW(AW), .RAW(RAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .bus_valid_i (bus_valid_i),
  .dec_valid_o (dec_valid_o),
  .cs_en_o     (cs_en_o),
  .offset_o    (offset_o),
  .miss_o      (miss_o)
);

// File: tb/flash_window_decoder_tb.sv
module flash_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        dec_valid;
  logic [2:0]  cs_en;
  logic [31:0] offset;
  logic        miss;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  flash_window_decoder u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (reg_we),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .bus_valid_i (bus_valid),
    .bus_addr_i  (bus_addr),
    .dec_valid_o (dec_valid),
    .cs_en_o     (cs_en),
    .offset_o    (offset),
    .miss_o      (miss)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  cs;
    logic        miss;
    logic [31:0] off;
  } vec_t;

  // default layout: R4 range, R5 priority, R6 offset
  localparam vec_t VECS [11] = '{
    '{32'h2000_0000, 3'b001, 1'b0, 32'h0000_0000},
    '{32'h27FF_FFFC, 3'b001, 1'b0, 32'h07FF_FFFC},
    '{32'h2800_0000, 3'b010, 1'b0, 32'h0000_0000},
    '{32'h29FF_FFFF, 3'b010, 1'b0, 32'h01FF_FFFF},
    '{32'h2A00_0000, 3'b100, 1'b0, 32'h0000_0000},
    '{32'h2BFF_FFF0, 3'b100, 1'b0, 32'h01FF_FFF0},
    '{32'h2C00_0000, 3'b001, 1'b0, 32'h0C00_0000},
    '{32'h2FFF_FFFF, 3'b001, 1'b0, 32'h0FFF_FFFF},
    '{32'h3000_0000, 3'b000, 1'b1, 32'h0000_0000},
    '{32'h1FFF_FFFF, 3'b000, 1'b1, 32'h0000_0000},
    '{32'hA000_0000, 3'b000, 1'b1, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic dec_chk(input string req, input logic [31:0] a, input logic [2:0] ecs,
                         input logic emiss, input logic [31:0] eoff);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk({req, " valid"}, {31'b0, dec_valid}, 32'd1);
    chk({req, " cs_en"}, {29'b0, cs_en}, {29'b0, ecs});
    chk({req, " miss"},  {31'b0, miss}, {31'b0, emiss});
    chk({req, " offset"}, offset, eoff);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dec_valid in reset", {31'b0, dec_valid}, 32'd0);
    chk("R1 cs_en in reset", {29'b0, cs_en}, 32'd0);
    rst_n = 1'b1;
    rd_chk("R1 cs0 default", 8'h30, 32'h6040_0000);
    rd_chk("R1 cs1 default", 8'h34, 32'h5450_0000);
    rd_chk("R1 cs2 default", 8'h38, 32'h5854_0000);
    rd_chk("R2 unmapped offset reads zero", 8'h3C, 32'h0);

    for (int i = 0; i < 11; i++)
      dec_chk("R4 R5 R6 table", VECS[i].addr, VECS[i].cs, VECS[i].miss, VECS[i].off);

    // R7 idle: no valid, no result
    @(negedge clk);
    chk("R7 idle valid", {31'b0, dec_valid}, 32'd0);
    chk("R7 idle cs_en", {29'b0, cs_en}, 32'd0);
    chk("R7 idle miss", {31'b0, miss}, 32'd0);

    // R2 write to unmapped offset has no effect
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped write cs0", 8'h30, 32'h6040_0000);
    rd_chk("R2 unmapped write cs2", 8'h38, 32'h5854_0000);

    // R3 cs0 start read-only; R4 end below start -> empty
    wr(8'h30, 32'h3811_1234);
    rd_chk("R3 cs0 start kept", 8'h30, 32'h3840_0000);
    dec_chk("R4 empty cs0 miss", 32'h2000_0000, 3'b000, 1'b1, 32'h0);

    // R3 cs2 end read-only; start above end -> empty
    wr(8'h38, 32'h00AA_0000);
    rd_chk("R3 cs2 end kept", 8'h38, 32'h58AA_0000);
    dec_chk("R4 inverted cs2 miss", 32'h2A00_0000, 3'b000, 1'b1, 32'h0);

    // R5 overlapping layout: cs2 spans 0x22000000..0x2BFFFFFF
    wr(8'h38, 32'h0044_0000);
    wr(8'h30, 32'h6000_0000);
    rd_chk("R2 cs0 rewritten", 8'h30, 32'h6040_0000);
    dec_chk("R5 triple overlap cs2 wins", 32'h2900_0000, 3'b100, 1'b0, 32'h0700_0000);
    dec_chk("R5 cs0 below cs2", 32'h2100_0000, 3'b001, 1'b0, 32'h0100_0000);
    dec_chk("R6 cs0 above cs2", 32'h2C00_0000, 3'b001, 1'b0, 32'h0C00_0000);

    // R4 end equal start -> empty
    wr(8'h38, 32'h0054_0000);
    wr(8'h34, 32'h5050_0000);
    dec_chk("R4 equal bounds cs1 empty", 32'h2800_0000, 3'b000 | 3'b001, 1'b0, 32'h0800_0000);
    dec_chk("R4 cs2 end exclusive", 32'h2C00_0000, 3'b001, 1'b0, 32'h0C00_0000);

    // R7 back-to-back decode
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 32'h2A00_0010;
    @(negedge clk);
    bus_addr = 32'h3100_0000;
    chk("R7 b2b first cs_en", {29'b0, cs_en}, 32'd4);
    chk("R6 b2b first offset", offset, 32'h10);
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R7 b2b second miss", {31'b0, miss}, 32'd1);
    chk("R7 b2b second valid", {31'b0, dec_valid}, 32'd1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule